// File: doc/BRIEF.md
# Quad DAC Serial Command Transmitter

This block is the host-side driver for a four-channel 8-bit digital-to-analog converter with an 11-bit serial command port. A client hands it one request at a time over a valid/ready handshake. A write request carries a channel number, a gain bit, an 8-bit code and a mode flag. A commit request carries none of these. For each write the block shifts out the 11-bit command on a generated serial clock and then pulses the word latch strobe. The converter samples the data line on each falling edge of the serial clock.

A write in immediate mode holds the update line low for the whole transfer, so the addressed channel changes output as soon as the word is latched. A write in staged mode keeps the update line high, so the converter only stores the value. A later commit request drives a single low pulse on the update line, and all four channels then change output together. The serial timing is set by a half-period count supplied with each request, in system clocks. The count is captured when the request is accepted.

Top module: `qdac_serial_tx`

## Requirements
- R1: After reset, and whenever no request is in progress, `req_ready` is 1, `dac_sclk` is 0, `dac_latch_n` is 1 and `dac_update_n` is 1.
- R2: A write produces exactly 11 falling edges of `dac_sclk`, carrying the word {chan[1:0], gain, code[7:0]} with the most significant bit first. The two channel bits go out first, then the gain bit (1 selects the doubled output range), then the code from bit 7 down to bit 0.
- R3: `dac_sdata` changes only while `dac_sclk` is high or at its rising edge. It holds the same value in the cycles just before and just after every falling edge.
- R4: Let H be `req_half_period`, with 0 treated as 1, captured on acceptance. Each serial bit is high for H system clocks and then low for H system clocks. The first high phase begins in the cycle after acceptance.
- R5: After the low phase of the 11th bit, `dac_latch_n` is driven low for 2·H system clocks and then returns high. `dac_sclk` stays low throughout.
- R6: For a write with `req_staged` = 0, `dac_update_n` is low from the cycle after acceptance until `dac_latch_n` returns high, so it is low at the falling edge of `dac_latch_n`.
- R7: For a write with `req_staged` = 1, `dac_update_n` stays high for the whole transfer, including the latch pulse.
- R8: A request with `req_commit` = 1 drives `dac_update_n` low for 2·H system clocks. It produces no `dac_sclk` edge and no `dac_latch_n` pulse, and it ignores the channel, gain, code and mode inputs.
- R9: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 from the next cycle until the cycle after the latch or update pulse ends, and a request held valid meanwhile waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_commit | input | 1 | 1: commit-only request (update pulse, no word) |
| req_chan | input | 2 | Target channel number |
| req_gain | input | 1 | Gain bit; 1 doubles the output range |
| req_code | input | 8 | Output code |
| req_staged | input | 1 | 1: stage only; 0: update immediately |
| req_half_period | input | 8 | Serial clock half period in system clocks (0 acts as 1) |
| dac_sclk | output | 1 | Serial clock, idles low |
| dac_sdata | output | 1 | Serial data |
| dac_latch_n | output | 1 | Word latch strobe, active low |
| dac_update_n | output | 1 | Output update control, active low |

## Verification
The checker assumes the client follows the handshake. The request fields only matter on the accepting edge, and nothing besides a request moves the serial lines. It also assumes reset is held from time zero until the first clock edge. The bench drives each request at a falling system clock edge and holds it until it sees `req_ready` high. It drops `req_valid` right after the accepting edge and never changes the fields in between. It models the converter by sampling the serial lines once per system clock. It compares every latched word and every commit pulse against a queue of expected events.

// File: rtl/qdac_pkg.sv
// Package: shared types for the quad DAC serial transmitter.
// Assumes: nothing; holds declarations only.
package qdac_pkg;

    // Transfer sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_LATCH  = 2'd2,
        ST_STROBE = 2'd3
    } qdac_state_e;

endpackage

// File: rtl/qdac_phase_timer.sv
// Module: counts system clocks within a serial phase and pulses `tick`
// on the last clock of each phase.
// Assumes: limit >= 1 and stable while run is high.
module qdac_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == limit - 1'b1);

    // Phase counter: cleared when idle or at the end of a phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/qdac_word_shifter.sv
// Module: parallel-load, left-shift register that presents its MSB as
// the serial data bit.
// Assumes: load and shift are never requested in the same cycle.
module qdac_word_shifter #(
    parameter int WIDTH = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_word,
    input  logic             shift,
    output logic             msb
);

    logic [WIDTH-1:0] sreg;

    assign msb = sreg[WIDTH-1];

    // Shift register: load a new word or move one bit toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= load_word;
        end else if (shift) begin
            sreg <= {sreg[WIDTH-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/qdac_serial_tx.sv
// Module: host-side transmitter for a four-channel serial DAC. It
// accepts write or commit requests over valid/ready, sends the command
// word MSB first, and then pulses the latch strobe (write) or the
// update strobe (commit).
// Assumes: request fields are stable on the accepting edge; the
// converter samples data on the falling edge of the serial clock.
module qdac_serial_tx #(
    parameter int CHAN_W = 2,
    parameter int CODE_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_commit,
    input  logic [CHAN_W-1:0] req_chan,
    input  logic              req_gain,
    input  logic [CODE_W-1:0] req_code,
    input  logic              req_staged,
    input  logic [DIV_W-1:0]  req_half_period,
    output logic              dac_sclk,
    output logic              dac_sdata,
    output logic              dac_latch_n,
    output logic              dac_update_n
);
    import qdac_pkg::*;

    localparam int WORD_W = CHAN_W + 1 + CODE_W;
    localparam int IDX_W  = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    qdac_state_e      state;
    logic [DIV_W-1:0] half_q;
    logic             ph_low;
    logic [IDX_W-1:0] bit_idx;
    logic             sclk_q;
    logic             latch_q;
    logic             update_q;
    logic             tick;
    logic             accept;
    logic             load_word;
    logic             shift_bit;

    assign req_ready    = (state == ST_IDLE);
    assign accept       = req_valid && req_ready;
    assign load_word    = accept && !req_commit;
    assign shift_bit    = (state == ST_SHIFT) && tick && ph_low && (bit_idx != LAST_IDX);
    assign dac_sclk     = sclk_q;
    assign dac_latch_n  = latch_q;
    assign dac_update_n = update_q;

    qdac_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state != ST_IDLE),
        .limit (half_q),
        .tick  (tick)
    );

    qdac_word_shifter #(.WIDTH(WORD_W)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_word),
        .load_word ({req_chan, req_gain, req_code}),
        .shift     (shift_bit),
        .msb       (dac_sdata)
    );

    // Transfer sequencer: serial phases, latch pulse and update pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            half_q   <= DIV_W'(1);
            ph_low   <= 1'b0;
            bit_idx  <= '0;
            sclk_q   <= 1'b0;
            latch_q  <= 1'b1;
            update_q <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        half_q  <= (req_half_period == '0) ? DIV_W'(1) : req_half_period;
                        ph_low  <= 1'b0;
                        bit_idx <= '0;
                        if (req_commit) begin
                            state    <= ST_STROBE;
                            update_q <= 1'b0;
                        end else begin
                            state    <= ST_SHIFT;
                            sclk_q   <= 1'b1;
                            update_q <= req_staged;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!ph_low) begin
                            sclk_q <= 1'b0;
                            ph_low <= 1'b1;
                        end else if (bit_idx == LAST_IDX) begin
                            state   <= ST_LATCH;
                            latch_q <= 1'b0;
                            ph_low  <= 1'b0;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            sclk_q  <= 1'b1;
                            ph_low  <= 1'b0;
                        end
                    end
                end
                ST_LATCH: begin
                    if (tick) begin
                        if (!ph_low) begin
                            ph_low <= 1'b1;
                        end else begin
                            latch_q  <= 1'b1;
                            update_q <= 1'b1;
                            ph_low   <= 1'b0;
                            state    <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        if (!ph_low) begin
                            ph_low <= 1'b1;
                        end else begin
                            update_q <= 1'b1;
                            ph_low   <= 1'b0;
                            state    <= ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/qdac_serial_tx_checks.sv
// Module: protocol checker for qdac_serial_tx, bound to every instance.
// Assumes: reset is asserted from time zero.
module qdac_serial_tx_checks (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic dac_sclk,
    input logic dac_sdata,
    input logic dac_latch_n,
    input logic dac_update_n
);

    // R1: no activity on any strobe while ready
    a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!dac_sclk && dac_latch_n && dac_update_n));

    // R3: data does not move across a serial falling edge
    a_r3_stable_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_sclk) |-> $stable(dac_sdata));

    // R5: the latch pulse happens with the serial clock low
    a_r5_latch_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_latch_n |-> !dac_sclk);

    // R6: the update line does not move inside a serial high phase
    a_r6_update_steady_in_word: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_sclk && $past(dac_sclk)) |-> $stable(dac_update_n));

    // R9: busy right after acceptance
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind qdac_serial_tx qdac_serial_tx_checks u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .dac_sclk     (dac_sclk),
    .dac_sdata    (dac_sdata),
    .dac_latch_n  (dac_latch_n),
    .dac_update_n (dac_update_n)
);

// File: tb/test_qdac_serial_tx.sv
module test_qdac_serial_tx;

    typedef struct {
        bit          is_commit;
        bit          staged;
        logic [10:0] word;
        int          half;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_commit = 1'b0;
    logic [1:0] req_chan = '0;
    logic       req_gain = 1'b0;
    logic [7:0] req_code = '0;
    logic       req_staged = 1'b0;
    logic [7:0] req_half_period = 8'd1;
    logic       dac_sclk, dac_sdata, dac_latch_n, dac_update_n;

    int   n_checks = 0;
    int   n_fail   = 0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    qdac_serial_tx i_qdac_serial_tx (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_commit      (req_commit),
        .req_chan        (req_chan),
        .req_gain        (req_gain),
        .req_code        (req_code),
        .req_staged      (req_staged),
        .req_half_period (req_half_period),
        .dac_sclk        (dac_sclk),
        .dac_sdata       (dac_sdata),
        .dac_latch_n     (dac_latch_n),
        .dac_update_n    (dac_update_n)
    );

    function automatic void chk(bit ok, string req, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endfunction

    // Driver: queue the expected event, then present the request.
    task automatic send(bit commit, logic [1:0] chan, logic gain, logic [7:0] code,
                        bit staged, logic [7:0] half);
        exp_t e;
        e.is_commit = commit;
        e.staged    = staged;
        e.word      = {chan, gain, code};
        e.half      = (half == 0) ? 1 : int'(half);
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_commit = commit; req_chan = chan; req_gain = gain;
        req_code = code; req_staged = staged; req_half_period = half;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b0, "R9 ready low after accept", int'(req_ready), 0);
    endtask

    // Monitor: models the converter and compares against the queue.
    logic        p_s = 1'b0, p_d = 1'b0, p_l = 1'b1, p_u = 1'b1;
    logic [10:0] bits = '0;
    int          nbits = 0, hi_len = 0, lat_len = 0, upd_len = 0;
    bit          unstable = 0, bad_hi = 0, saw_act = 0, upd_at_latch = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            int h;
            exp_t e;
            h = (exp_q.size() > 0) ? exp_q[0].half : 1;
            if (dac_sclk) hi_len++;
            if (p_s && !dac_sclk) begin
                bits = {bits[9:0], p_d};
                nbits++;
                if (p_d != dac_sdata) unstable = 1;
                if (hi_len != h) bad_hi = 1;
                hi_len = 0;
                saw_act = 1;
            end
            if (p_l && !dac_latch_n) begin
                upd_at_latch = dac_update_n;
                lat_len = 0;
                saw_act = 1;
            end
            if (!dac_latch_n) lat_len++;
            if (!p_l && dac_latch_n) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2 unexpected word", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(!e.is_commit, "R2 word where commit expected", 1, 0);
                    chk(nbits == 11, "R2 bit count", nbits, 11);
                    chk(bits == e.word, "R2 word value", int'(bits), int'(e.word));
                    chk(!unstable, "R3 data stable at fall", int'(unstable), 0);
                    chk(!bad_hi, "R4 high phase length", int'(bad_hi), 0);
                    chk(lat_len == 2 * e.half, "R5 latch width", lat_len, 2 * e.half);
                    if (e.staged)
                        chk(upd_at_latch == 1'b1, "R7 update high when staged", int'(upd_at_latch), 1);
                    else
                        chk(upd_at_latch == 1'b0, "R6 update low when immediate", int'(upd_at_latch), 0);
                end
                nbits = 0; unstable = 0; bad_hi = 0;
            end
            if (p_u && !dac_update_n) begin
                upd_len = 0;
                saw_act = 0;
            end
            if (!dac_update_n) upd_len++;
            if (!p_u && dac_update_n && !saw_act) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R8 unexpected commit", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(e.is_commit, "R8 commit where word expected", 0, 1);
                    chk(upd_len == 2 * e.half, "R8 commit width", upd_len, 2 * e.half);
                end
            end
            p_s = dac_sclk; p_d = dac_sdata; p_l = dac_latch_n; p_u = dac_update_n;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(dac_sclk == 1'b0, "R1 sclk idle low", int'(dac_sclk), 0);
        chk(dac_latch_n == 1'b1, "R1 latch idle high", int'(dac_latch_n), 1);
        chk(dac_update_n == 1'b1, "R1 update idle high", int'(dac_update_n), 1);

        // Immediate writes, all channels, several dividers (R2 R4 R5 R6)
        send(0, 2'd0, 1'b0, 8'h00, 0, 8'd1);
        send(0, 2'd1, 1'b1, 8'hFF, 0, 8'd2);
        send(0, 2'd2, 1'b0, 8'hA5, 0, 8'd3);
        send(0, 2'd3, 1'b1, 8'h5A, 0, 8'd0);
        // Staged writes then one commit (R7 R8); commit ignores fields
        send(0, 2'd1, 1'b0, 8'h81, 1, 8'd2);
        send(0, 2'd2, 1'b1, 8'h7E, 1, 8'd2);
        send(0, 2'd3, 1'b0, 8'h01, 1, 8'd1);
        send(1, 2'd3, 1'b1, 8'hFF, 0, 8'd2);
        // Commit with zero divider, then a back-to-back immediate write (R9)
        send(1, 2'd0, 1'b0, 8'h00, 1, 8'd0);
        send(0, 2'd0, 1'b1, 8'hC3, 0, 8'd4);

        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all events seen", exp_q.size(), 0);
        chk(req_ready == 1'b1, "R1 ready when done", int'(req_ready), 1);
        chk(dac_latch_n && dac_update_n && !dac_sclk, "R1 lines idle when done",
            int'({dac_sclk, dac_latch_n, dac_update_n}), 3);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule